// File: doc/BRIEF.md
# Programmable Almost-Full / Almost-Empty Flag Generator for a Dual-Clock FIFO

This block produces the two "nearly" status flags of a FIFO whose writer and reader run on unrelated clocks. The almost-full flag (`af_n`, active low) belongs to the write clock. The almost-empty flag (`ae_n`, active low) belongs to the read clock. The block keeps one pointer per side, advanced by single-cycle write and read events. Each pointer crosses to the other side in Gray code through a two-register synchronizer. Each flag compares the fill level seen on its own side against a programmable offset.

A flag moves into its active (low) state as soon as an operation on its own side reaches the threshold. It moves back to inactive only when the other side's pointer has passed through the synchronizer. That happens on the second rising edge of the flag's own clock after the causing operation. A word that the reader has already taken into its output register counts as read: the reader pulses `rd_inc` when that word leaves the array.

The full-side offset Y and the empty-side offset X take preset values at reset. Each can be rewritten afterwards from its own clock domain: Y from the write side and X from the read side. The memory array, the data paths and the hard full/empty flags are outside this block.

Top module: `fifo_level_flags`

## Requirements
- R1: While `rst_n` is low and right after reset, `af_n` is 1 and `ae_n` is 0. The offsets hold `Y_PRESET` (full side) and `X_PRESET` (empty side).
- R2: Once both pointers have settled, `af_n` is 0 when the stored word count is DEPTH−Y or more, and 1 when it is DEPTH−(Y+1) or less.
- R3: Once both pointers have settled, `ae_n` is 0 when the stored word count is X or less, and 1 when it is X+1 or more. A read event removes the word from the count.
- R4: A write accepted on a `wclk` rising edge that brings the count to DEPTH−Y drives `af_n` to 0 directly after that same edge.
- R5: A read accepted on a `rclk` rising edge that brings the count down to X drives `ae_n` to 0 directly after that same edge.
- R6: After a read lowers the count to DEPTH−(Y+1), `af_n` stays 0 after the first `wclk` rising edge that follows the read. It becomes 1 after the second.
- R7: After a write raises the count to X+1, `ae_n` stays 0 after the first `rclk` rising edge that follows the write. It becomes 1 after the second.
- R8: `cfg_full_we` high on a `wclk` edge loads Y from `cfg_full_val`, and `cfg_empty_we` high on a `rclk` edge loads X from `cfg_empty_val`. The new offset governs its flag directly after that edge.
- R9: The Gray-coded write and read pointers each change in at most one bit per edge of their own clock, and a flag only becomes active after a local operation or an offset load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_inc | input | 1 | One word written into the array this `wclk` cycle |
| rd_inc | input | 1 | One word removed from the array this `rclk` cycle |
| cfg_full_we | input | 1 | Load the full-side offset Y (write clock) |
| cfg_full_val | input | AW | New Y value |
| cfg_empty_we | input | 1 | Load the empty-side offset X (read clock) |
| cfg_empty_val | input | AW | New X value |
| af_n | output | 1 | Almost-full, active low, write clock |
| ae_n | output | 1 | Almost-empty, active low, read clock |

## Verification
The assertions check on every edge that the Gray pointers move by one bit at most and that the fill seen on the write side never exceeds DEPTH. They also check that each flag only falls after a local operation or an offset load. The bench scenarios show what the assertions cannot: the exact thresholds against a reference count, the immediate assertion on the local edge, and the deassertion landing on the second edge of the flag's clock and not the first. They also show the effect of reprogrammed offsets.

// File: rtl/fifo_level_flags.sv
module fifo_level_flags #(
  parameter int AW       = 4,
  parameter int X_PRESET = 2,
  parameter int Y_PRESET = 3
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_inc,
  input  logic          rd_inc,
  input  logic          cfg_full_we,
  input  logic [AW-1:0] cfg_full_val,
  input  logic          cfg_empty_we,
  input  logic [AW-1:0] cfg_empty_val,
  output logic          af_n,
  output logic          ae_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write side
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2, rbin_w, wfill;
  logic [AW-1:0] yoff;
  logic [PW:0]   af_lvl;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
      yoff  <= AW'(Y_PRESET);
    end else begin
      if (wr_inc) begin
        wbin  <= wbin + 1'b1;
        wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
      end
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (cfg_full_we) yoff <= cfg_full_val;
    end

  assign rbin_w = to_bin(rg_s2);
  assign wfill  = wbin - rbin_w;
  assign af_lvl = (PW+1)'(DEPTH) - {2'b00, yoff};
  assign af_n   = {1'b0, wfill} < af_lvl;

  // read side
  logic [PW-1:0] rbin, rgray, wg_s1, wg_s2, wbin_r, rfill;
  logic [AW-1:0] xoff;

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
      xoff  <= AW'(X_PRESET);
    end else begin
      if (rd_inc) begin
        rbin  <= rbin + 1'b1;
        rgray <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
      end
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (cfg_empty_we) xoff <= cfg_empty_val;
    end

  assign wbin_r = to_bin(wg_s2);
  assign rfill  = wbin_r - rbin;
  assign ae_n   = rfill > {1'b0, xoff};

  // R9
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray)));
  // R9
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    $onehot0(rgray ^ $past(rgray)));
  // R4
  af_fall_cause_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $fell(af_n) |-> ($past(wr_inc) || $past(cfg_full_we)));
  // R5
  ae_fall_cause_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    $fell(ae_n) |-> ($past(rd_inc) || $past(cfg_empty_we)));
  // R2
  wfill_bound_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    {1'b0, wfill} <= (PW+1)'(DEPTH));
endmodule

// File: tb/fifo_level_flags_tb.sv
`timescale 1ns/100ps
module fifo_level_flags_tb;
  localparam int AW = 4, DEPTH = 16, XP = 2, YP = 3;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wr_inc = 0, rd_inc = 0, cfg_full_we = 0, cfg_empty_we = 0;
  logic [AW-1:0] cfg_full_val = '0, cfg_empty_val = '0;
  logic af_n, ae_n;

  always #2.5 wclk = ~wclk;
  initial begin #1.0; forever begin rclk = 1; #4; rclk = 0; #4; end end

  fifo_level_flags #(.AW(AW), .X_PRESET(XP), .Y_PRESET(YP)) u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_inc(wr_inc), .rd_inc(rd_inc),
    .cfg_full_we(cfg_full_we), .cfg_full_val(cfg_full_val),
    .cfg_empty_we(cfg_empty_we), .cfg_empty_val(cfg_empty_val),
    .af_n(af_n), .ae_n(ae_n));

  typedef struct { string tag; bit is_af; bit exp; } item_t;
  item_t exp_q[$];
  int total = 0, bad = 0, cnt = 0, xv = XP, yv = YP;
  bit done = 0;

  task automatic expect_flag(string tag, bit is_af, bit exp);
    item_t it;
    it.tag = tag; it.is_af = is_af; it.exp = exp;
    exp_q.push_back(it);
    #0;
  endtask

  initial forever begin
    item_t it;
    bit act;
    wait (exp_q.size() != 0);
    it = exp_q.pop_front();
    act = it.is_af ? af_n : ae_n;
    total++;
    if (act !== it.exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", it.tag,
               it.is_af ? "af_n" : "ae_n", act, it.exp);
    end
  end

  task automatic wr1();
    @(posedge wclk); #0.2 wr_inc = 1;
    @(posedge wclk); #0.2 wr_inc = 0; cnt++;
  endtask
  task automatic rd1();
    @(posedge rclk); #0.2 rd_inc = 1;
    @(posedge rclk); #0.2 rd_inc = 0; cnt--;
  endtask
  task automatic settle();
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    #0.2;
  endtask
  task automatic check_steady(string tag);
    expect_flag(tag, 1, !(cnt >= DEPTH - yv));
    expect_flag(tag, 0, cnt > xv);
  endtask

  initial begin
    #12;
    expect_flag("R1 in reset", 1, 1);
    expect_flag("R1 in reset", 0, 0);
    rst_n = 1;
    settle();
    expect_flag("R1 after reset", 1, 1);
    expect_flag("R1 after reset", 0, 0);

    wr1(); wr1(); settle();
    check_steady("R3 count=X");
    // R7: third write lifts count to X+1
    wr1();
    @(posedge rclk); #0.2 expect_flag("R7 first rclk edge", 0, 0);
    @(posedge rclk); #0.2 expect_flag("R7 second rclk edge", 0, 1);
    settle(); check_steady("R3 count=X+1");

    while (cnt < DEPTH - yv - 1) wr1();
    settle(); check_steady("R2 count=DEPTH-Y-1");
    wr1();
    expect_flag("R4 immediate af", 1, 0);
    settle(); check_steady("R2 count=DEPTH-Y");
    wr1(); settle(); check_steady("R2 count=DEPTH-Y+1");
    rd1(); settle();
    // R6: read brings count to DEPTH-(Y+1)
    rd1();
    @(posedge wclk); #0.2 expect_flag("R6 first wclk edge", 1, 0);
    @(posedge wclk); #0.2 expect_flag("R6 second wclk edge", 1, 1);
    settle(); check_steady("R2 after reads");

    while (cnt > xv + 1) rd1();
    settle(); check_steady("R3 count=X+1 by reads");
    rd1();
    expect_flag("R5 immediate ae", 0, 0);
    settle(); check_steady("R3 back at X");

    // R8: reprogram Y to 8 and X to 6
    @(posedge wclk); #0.2 cfg_full_we = 1; cfg_full_val = 4'd8;
    @(posedge wclk); #0.2 cfg_full_we = 0; yv = 8;
    expect_flag("R8 new Y", 1, 1);
    while (cnt < 7) wr1();
    settle(); check_steady("R8 count=7 Y=8");
    wr1();
    expect_flag("R8 af at DEPTH-8", 1, 0);
    settle();
    @(posedge rclk); #0.2 cfg_empty_we = 1; cfg_empty_val = 4'd6;
    @(posedge rclk); #0.2 cfg_empty_we = 0; xv = 6;
    expect_flag("R8 new X count=8", 0, 1);
    rd1();
    rd1();
    expect_flag("R8 ae at X=6", 0, 0);
    settle(); check_steady("R8 final");

    #1;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule